// File: doc/BRIEF.md
# Integer Execute ALU with Immediate Extension

A single-cycle, purely combinational 32-bit execute unit for a three-operand register/register and register/immediate integer instruction set. A decoder upstream supplies an operation code, two register operands, a 16-bit immediate field and a 5-bit constant shift amount. In the same cycle the unit returns a 32-bit result, an overflow-trap flag and a write-enable for the destination register.

How the immediate is widened depends on the class of the operation, not on whether its name says "unsigned". Arithmetic and compare immediates are always sign-extended. Logical immediates are always zero-extended. Only the trapping add and subtract forms can raise the overflow trap. When they do, the write-enable drops so the destination register keeps its old value.

Top module: `alu_exec`

## Requirements
- R1: ADD(0), ADDU(1), SUB(2), SUBU(3) and ADDIU(11) return the two's-complement sum or difference modulo 2^32. ADDU, SUBU and ADDIU never raise `ovf_trap`.
- R2: ADD(0), SUB(2) and ADDI(10) raise `ovf_trap` exactly when the signed result does not fit in 32 bits. `wr_en` is low whenever `ovf_trap` is high, and `result` still carries the wrapped value.
- R3: ADDI(10), ADDIU(11), SLTI(12) and SLTIU(13) use `imm16` sign-extended to 32 bits as the second operand. SLTIU then compares unsigned against that extended value.
- R4: ANDI(14), ORI(15) and XORI(16) use `imm16` zero-extended, so `result[31:16]` equals `src_a[31:16]` masked by zero: AND gives 0, OR and XOR give `src_a`'s upper half.
- R5: LUI(17) returns `{imm16, 16'h0000}` regardless of the register operands.
- R6: SLT(8) and SLTI(12) return 1 when `src_a` is less than the second operand as signed numbers, else 0. SLTU(9) and SLTIU(13) compare the same operands as unsigned numbers.
- R7: AND(4), OR(5), XOR(6) and NOR(7) combine `src_a` and `src_b` bitwise. NOR returns the inverse of the OR.
- R8: SLL(18), SRL(19) and SRA(20) shift `src_b` by `shamt` (0 to 31). SRA fills with the sign bit of `src_b`, and SRL and SLL fill with zeros.
- R9: SLLV(21), SRLV(22) and SRAV(23) shift `src_b` by `src_a[4:0]`. Bits 31:5 of `src_a` have no effect.
- R10: Op codes 24 to 31 are undefined. They return a result of 0, `ovf_trap` low and `wr_en` low.
- R11: For every defined op code that does not trap, `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Decoded operation code (values listed in the requirements) |
| src_a | input | 32 | First register operand; also the variable shift amount |
| src_b | input | 32 | Second register operand; also the value being shifted |
| imm16 | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Computed value |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en | output | 1 | Destination register may be written |

## Verification
The unit holds no state, so a wrong decision inside it shows up at the ports in the same cycle it is presented. A wrong choice of extension flips the upper half of the result for negative immediates. A misplaced borrow or sign term flips the 0/1 answer of a compare near the sign boundary. A stray overflow term drops `wr_en` on an unsigned form. Directed operands at the signed and unsigned limits force each of these cases. A random sweep over every op code then compares each result with an independent model.

// File: rtl/alu_exec.sv
module alu_exec (
  input  logic [4:0]  op_sel,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [15:0] imm16,
  input  logic [4:0]  shamt,
  output logic [31:0] result,
  output logic        ovf_trap,
  output logic        wr_en
);

  localparam logic [4:0] OP_ADD   = 5'd0;
  localparam logic [4:0] OP_ADDU  = 5'd1;
  localparam logic [4:0] OP_SUB   = 5'd2;
  localparam logic [4:0] OP_SUBU  = 5'd3;
  localparam logic [4:0] OP_AND   = 5'd4;
  localparam logic [4:0] OP_OR    = 5'd5;
  localparam logic [4:0] OP_XOR   = 5'd6;
  localparam logic [4:0] OP_NOR   = 5'd7;
  localparam logic [4:0] OP_SLT   = 5'd8;
  localparam logic [4:0] OP_SLTU  = 5'd9;
  localparam logic [4:0] OP_ADDI  = 5'd10;
  localparam logic [4:0] OP_ADDIU = 5'd11;
  localparam logic [4:0] OP_SLTI  = 5'd12;
  localparam logic [4:0] OP_SLTIU = 5'd13;
  localparam logic [4:0] OP_ANDI  = 5'd14;
  localparam logic [4:0] OP_ORI   = 5'd15;
  localparam logic [4:0] OP_XORI  = 5'd16;
  localparam logic [4:0] OP_LUI   = 5'd17;
  localparam logic [4:0] OP_SLL   = 5'd18;
  localparam logic [4:0] OP_SRL   = 5'd19;
  localparam logic [4:0] OP_SRA   = 5'd20;
  localparam logic [4:0] OP_SLLV  = 5'd21;
  localparam logic [4:0] OP_SRLV  = 5'd22;
  localparam logic [4:0] OP_SRAV  = 5'd23;

  logic        imm_arith, imm_logic, do_sub, var_shift, known_op, trap_class;
  logic [31:0] opnd_b, b_inv, sum;
  logic        carry, sovf, lt_signed, lt_unsigned;
  logic [4:0]  sh_amt;
  logic [31:0] sh_left, sh_rlog, sh_rari;

  assign imm_arith = (op_sel == OP_ADDI) || (op_sel == OP_ADDIU) ||
                     (op_sel == OP_SLTI) || (op_sel == OP_SLTIU);
  assign imm_logic = (op_sel == OP_ANDI) || (op_sel == OP_ORI) || (op_sel == OP_XORI);

  assign opnd_b = imm_arith ? {{16{imm16[15]}}, imm16} :
                  imm_logic ? {16'h0000, imm16} : src_b;

  assign do_sub = (op_sel == OP_SUB)  || (op_sel == OP_SUBU) ||
                  (op_sel == OP_SLT)  || (op_sel == OP_SLTU) ||
                  (op_sel == OP_SLTI) || (op_sel == OP_SLTIU);

  assign b_inv        = do_sub ? ~opnd_b : opnd_b;
  assign {carry, sum} = {1'b0, src_a} + {1'b0, b_inv} + {32'd0, do_sub};

  assign sovf        = (src_a[31] == b_inv[31]) && (sum[31] != src_a[31]);
  assign lt_signed   = sum[31] ^ sovf;
  assign lt_unsigned = ~carry;

  assign var_shift = (op_sel == OP_SLLV) || (op_sel == OP_SRLV) || (op_sel == OP_SRAV);
  assign sh_amt    = var_shift ? src_a[4:0] : shamt;
  assign sh_left   = src_b << sh_amt;
  assign sh_rlog   = src_b >> sh_amt;
  assign sh_rari   = $signed(src_b) >>> sh_amt;

  always_comb begin
    known_op = 1'b1;
    case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
      OP_ADDI, OP_ADDIU:             result = sum;
      OP_AND, OP_ANDI:               result = src_a & opnd_b;
      OP_OR, OP_ORI:                 result = src_a | opnd_b;
      OP_XOR, OP_XORI:               result = src_a ^ opnd_b;
      OP_NOR:                        result = ~(src_a | opnd_b);
      OP_SLT, OP_SLTI:               result = {31'd0, lt_signed};
      OP_SLTU, OP_SLTIU:             result = {31'd0, lt_unsigned};
      OP_LUI:                        result = {imm16, 16'h0000};
      OP_SLL, OP_SLLV:               result = sh_left;
      OP_SRL, OP_SRLV:               result = sh_rlog;
      OP_SRA, OP_SRAV:               result = sh_rari;
      default: begin
        result   = 32'd0;
        known_op = 1'b0;
      end
    endcase
  end

  assign trap_class = (op_sel == OP_ADD) || (op_sel == OP_SUB) || (op_sel == OP_ADDI);
  assign ovf_trap   = trap_class & sovf;
  assign wr_en      = known_op & ~ovf_trap;

  always_comb begin
    // R2: a trapping operation never writes back
    a_r2_no_write_on_trap: assert (!(ovf_trap && wr_en));
    if (op_sel == OP_ADDU || op_sel == OP_SUBU || op_sel == OP_ADDIU)
      a_r1_unsigned_no_trap: assert (!ovf_trap && wr_en);
    if (op_sel == OP_LUI)
      a_r5_lui_low_zero: assert (result[15:0] == 16'h0000);
    if (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU)
      a_r6_compare_is_bit: assert (result[31:1] == 31'd0);
    if (op_sel == OP_ANDI)
      a_r4_andi_upper_zero: assert (result[31:16] == 16'h0000);
    if (op_sel > OP_SRAV)
      a_r10_undef_quiet: assert (result == 32'd0 && !wr_en && !ovf_trap);
  end

endmodule

// File: tb/test_alu_exec.sv
module test_alu_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf_trap, wr_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] q_res[$];
  logic        q_trap[$];
  logic        q_we[$];
  string       q_tag[$];

  alu_exec i_alu_exec (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
    .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh,
                                output logic [31:0] r, output logic t, output logic w);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint si = longint'($signed(im));
    logic [31:0] ext_s = 32'(si);
    logic [31:0] ext_z = {16'h0000, im};
    longint wide = 0;
    r = '0; t = 1'b0; w = 1'b1;
    case (op)
      5'd0:  begin wide = sa + sb; r = wide[31:0]; t = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      5'd1:  r = a + b;
      5'd2:  begin wide = sa - sb; r = wide[31:0]; t = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      5'd3:  r = a - b;
      5'd4:  r = a & b;
      5'd5:  r = a | b;
      5'd6:  r = a ^ b;
      5'd7:  r = ~(a | b);
      5'd8:  r = (sa < sb) ? 32'd1 : 32'd0;
      5'd9:  r = (a < b) ? 32'd1 : 32'd0;
      5'd10: begin wide = sa + si; r = wide[31:0]; t = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      5'd11: r = a + ext_s;
      5'd12: r = (sa < si) ? 32'd1 : 32'd0;
      5'd13: r = (a < ext_s) ? 32'd1 : 32'd0;
      5'd14: r = a & ext_z;
      5'd15: r = a | ext_z;
      5'd16: r = a ^ ext_z;
      5'd17: r = {im, 16'h0000};
      5'd18: r = b << sh;
      5'd19: r = b >> sh;
      5'd20: r = 32'($signed(b) >>> sh);
      5'd21: r = b << a[4:0];
      5'd22: r = b >> a[4:0];
      5'd23: r = 32'($signed(b) >>> a[4:0]);
      default: w = 1'b0;
    endcase
    if (t) w = 1'b0;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input string tag);
    logic [31:0] r;
    logic t, w;
    @(posedge clk);
    op_sel = op; src_a = a; src_b = b; imm16 = im; shamt = sh;
    model(op, a, b, im, sh, r, t, w);
    q_res.push_back(r); q_trap.push_back(t); q_we.push_back(w); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && q_res.size() > 0) begin
      logic [31:0] er;
      logic et, ew;
      string tg;
      er = q_res.pop_front(); et = q_trap.pop_front(); ew = q_we.pop_front(); tg = q_tag.pop_front();
      n_cmp++;
      if (result !== er || ovf_trap !== et || wr_en !== ew) begin
        n_bad++;
        $display("FAIL %s op=%0d: got res=%h trap=%b we=%b, expected res=%h trap=%b we=%b",
                 tg, op_sel, result, ovf_trap, wr_en, er, et, ew);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(5'd0,  32'h0, 32'h0, 16'h0, 5'd0, "R11 idle add zero");
    drive(5'd1,  32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R1 addu wrap no trap");
    drive(5'd3,  32'd5, 32'd7, 16'h0, 5'd0, "R1 subu negative");
    drive(5'd11, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, "R1 addiu no trap");
    drive(5'd0,  32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R2 add overflow");
    drive(5'd0,  32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0, "R2 add neg overflow");
    drive(5'd2,  32'h80000000, 32'h1, 16'h0, 5'd0, "R2 sub overflow");
    drive(5'd2,  32'h0, 32'h80000000, 16'h0, 5'd0, "R2 sub min overflow");
    drive(5'd10, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, "R2 addi overflow");
    drive(5'd0,  32'h7FFFFFFE, 32'h1, 16'h0, 5'd0, "R2 add at limit");
    drive(5'd11, 32'd10, 32'h0, 16'hFFCE, 5'd0, "R3 addiu sign-extends");
    drive(5'd10, 32'd10, 32'h0, 16'h8000, 5'd0, "R3 addi negative imm");
    drive(5'd13, 32'd5, 32'h0, 16'hFFFF, 5'd0, "R3 sltiu extended all-ones");
    drive(5'd12, 32'd5, 32'h0, 16'hFFFF, 5'd0, "R3 slti minus one");
    drive(5'd14, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, "R4 andi zero-extends");
    drive(5'd15, 32'h0, 32'h0, 16'hFFFF, 5'd0, "R4 ori zero-extends");
    drive(5'd16, 32'hA5A5A5A5, 32'h0, 16'hFFFF, 5'd0, "R4 xori upper kept");
    drive(5'd17, 32'hDEADBEEF, 32'hCAFEF00D, 16'h1234, 5'd7, "R5 lui");
    drive(5'd8,  32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, "R6 slt signed");
    drive(5'd9,  32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, "R6 sltu unsigned");
    drive(5'd8,  32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, "R6 slt extremes");
    drive(5'd9,  32'h3, 32'h3, 16'h0, 5'd0, "R6 sltu equal");
    drive(5'd7,  32'hF0F00000, 32'h0000F0F0, 16'h0, 5'd0, "R7 nor");
    drive(5'd4,  32'hFF00FF00, 32'h0FF00FF0, 16'h0, 5'd0, "R7 and");
    drive(5'd6,  32'hFFFF0000, 32'h00FFFF00, 16'h0, 5'd0, "R7 xor");
    drive(5'd18, 32'h0, 32'h1, 16'h0, 5'd31, "R8 sll by 31");
    drive(5'd20, 32'h0, 32'h80000000, 16'h0, 5'd4, "R8 sra sign fill");
    drive(5'd19, 32'h0, 32'h80000000, 16'h0, 5'd4, "R8 srl zero fill");
    drive(5'd20, 32'h0, 32'h12345678, 16'h0, 5'd0, "R8 sra by 0");
    drive(5'd21, 32'hFFFFFFE3, 32'h1, 16'h0, 5'd0, "R9 sllv low bits only");
    drive(5'd23, 32'h00000024, 32'h80000000, 16'h0, 5'd9, "R9 srav ignores shamt");
    drive(5'd22, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, "R9 srlv by 31");
    drive(5'd24, 32'h12345678, 32'h9ABCDEF0, 16'hFFFF, 5'd3, "R10 undefined 24");
    drive(5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31, "R10 undefined 31");
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 23));
      drive(op, $urandom, $urandom, 16'($urandom), 5'($urandom), "R11 random sweep");
    end
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule